// File: doc/BRIEF.md
# Power Mode and Autosleep Controller

This block manages the power state of a small peripheral chip. The chip has three states. In the operational state the fast RC oscillator runs. In sleep only the 32 kHz domain runs. In hibernate no clock runs at all. Two control registers are written over a simple register bus, and only while the chip is operational. They hold the mode request bits, the per-module clock enables, the 32 kHz source select, the I/O-bank shutdown flag and the autosleep settings.

The block decides when to leave each state. The inputs that can cause a move are traffic addressed to this device, a hotkey or interrupt wake event, a raw keypress detect and the pass or fail result of an external debouncer. A keypress seen in hibernate moves the chip into a "key check" form of sleep so that the key can be debounced. A failed key sends the chip back to hibernate. An autosleep timer counts 32 kHz ticks while the chip is operational. Only completed transactions addressed to this device restart it. When the programmed timeout elapses, the chip drops into sleep.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset: `ctl_q`=0x0F, `ctl2_q`=0x00, `pwr_state`=00 (operational), both oscillator enables are 1 and all three module clock enables are 1. The `pwr_state` encoding is 00 operational, 01 sleep, 10 hibernate.
- R2: The module clock enables come from the main register: bit 3 drives GPIO, bit 1 drives keypad and bit 0 drives PWM. They apply in the operational and sleep states and are all 0 in hibernate. Bit 2 is reserved and always reads 1.
- R3: Writing bit 4 of the main register moves the operational state to sleep at the next clock edge, and the bit reads 0 afterwards. In sleep `rc_osc_en`=0 and `osc32_en`=1.
- R4: Sleep returns to operational one cycle after either `dev_hit` or `wake_evt`.
- R5: Writing bit 5 of the main register enters hibernate at the next edge, and the bit reads 0 afterwards. All oscillator and module clock enables are 0 in hibernate. Bit 5 wins over bit 4 when both are written.
- R6: In hibernate, `dev_hit` moves the chip to operational and `key_detect` moves it to sleep (key check). `wake_evt` has no effect there.
- R7: In key check, `key_invalid` returns the chip to hibernate and `key_valid` leaves it in ordinary sleep. In ordinary sleep, a later `key_invalid` has no effect.
- R8: When bit 3 of the second register is set, the timeout code in bits [2:0] gives 0→4, 1→16, 2→32, 3→64, 4→128, 5→256, 6→512 and 7→1024 ms. The chip enters sleep on the edge of tick number (ms × `TICKS_PER_MS`) counted after the enable takes effect.
- R9: A `dev_hit` restarts the autosleep count, and wins over a tick in the same cycle. The count is held at zero while autosleep is disabled or the chip is not operational.
- R10: Register writes are ignored unless the chip is operational.
- R11: Writing bit 7 of the main register raises `soft_rst_o` for exactly one cycle. At the following edge both registers return to their reset values and the state returns to operational.
- R12: `ext32_sel` follows main-register bit 6, and `io_hi_off` follows second-register bit 4. Bits [7:5] of the second register read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 1 | 0 = main control register, 1 = second control register |
| reg_wdata | input | 8 | Write data |
| ctl_q | output | 8 | Main control register value |
| ctl2_q | output | 8 | Second control register value |
| tick_32k | input | 1 | One-cycle pulse per 32 kHz period |
| dev_hit | input | 1 | Completed transaction addressed to this device |
| wake_evt | input | 1 | Hotkey, wakeup pin or enabled interrupt event |
| key_detect | input | 1 | Raw keypress detect |
| key_valid | input | 1 | Debouncer reports a valid key |
| key_invalid | input | 1 | Debouncer reports a rejected key |
| pwr_state | output | 2 | 00 operational, 01 sleep, 10 hibernate |
| rc_osc_en | output | 1 | Fast RC oscillator enable |
| osc32_en | output | 1 | 32 kHz oscillator enable |
| ext32_sel | output | 1 | Select the external 32 kHz clock |
| gpio_clk_en | output | 1 | GPIO module clock enable |
| kpc_clk_en | output | 1 | Keypad module clock enable |
| pwm_clk_en | output | 1 | PWM module clock enable |
| io_hi_off | output | 1 | Force the high-bank level shifters off |
| soft_rst_o | output | 1 | Single-cycle soft-reset pulse |

## Verification
The autosleep timer is swept over all eight timeout codes with a tick on every cycle, and the exact edge of sleep entry is compared with ms × `TICKS_PER_MS`. A restart in the middle of a count checks that `dev_hit` resets the count rather than pausing it. The state machine is driven with each wake source in each state. Hibernate sees `wake_evt` (ignored), `key_detect` and `dev_hit`. Key check sees both debouncer results. Ordinary sleep sees the stray `key_invalid`. Together these separate ordinary sleep from key-check sleep, which look the same on the state output. Writes made in sleep and a soft reset issued with non-default register contents show which state the bus write path and the reset path actually reach.

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl #(
  parameter int TICKS_PER_MS = 32
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic       reg_addr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] ctl_q,
  output logic [7:0] ctl2_q,
  input  logic       tick_32k,
  input  logic       dev_hit,
  input  logic       wake_evt,
  input  logic       key_detect,
  input  logic       key_valid,
  input  logic       key_invalid,
  output logic [1:0] pwr_state,
  output logic       rc_osc_en,
  output logic       osc32_en,
  output logic       ext32_sel,
  output logic       gpio_clk_en,
  output logic       kpc_clk_en,
  output logic       pwm_clk_en,
  output logic       io_hi_off,
  output logic       soft_rst_o
);

  localparam int LIM_MAX = 1024 * TICKS_PER_MS;
  localparam int CW      = $clog2(LIM_MAX + 1);
  localparam logic [7:0] CTL_RST = 8'h0F;

  typedef enum logic [1:0] {ST_OP = 2'd0, ST_SLP = 2'd1, ST_HIB = 2'd2, ST_KEY = 2'd3} st_t;

  st_t          st;
  logic [CW-1:0] cnt;
  logic [10:0]  ms;
  logic [31:0]  lim32;
  logic [CW-1:0] lim;
  logic         as_on, as_fire, bus_ok;

  assign ms      = (ctl2_q[2:0] == 3'd0) ? 11'd4 : (11'd8 << ctl2_q[2:0]);
  assign lim32   = {21'd0, ms} * 32'(TICKS_PER_MS);
  assign lim     = lim32[CW-1:0];
  assign as_on   = (st == ST_OP) && ctl2_q[3];
  assign as_fire = as_on && !dev_hit && tick_32k && (cnt >= lim - 1'b1);
  assign bus_ok  = reg_wr && (st == ST_OP);

  assign soft_rst_o  = ctl_q[7];
  assign pwr_state   = (st == ST_KEY) ? ST_SLP : st;
  assign rc_osc_en   = (st == ST_OP);
  assign osc32_en    = (st != ST_HIB);
  assign ext32_sel   = ctl_q[6];
  assign gpio_clk_en = ctl_q[3] && osc32_en;
  assign kpc_clk_en  = ctl_q[1] && osc32_en;
  assign pwm_clk_en  = ctl_q[0] && osc32_en;
  assign io_hi_off   = ctl2_q[4];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl_q  <= CTL_RST;
      ctl2_q <= 8'h00;
      st     <= ST_OP;
      cnt    <= '0;
    end else if (ctl_q[7]) begin
      ctl_q  <= CTL_RST;
      ctl2_q <= 8'h00;
      st     <= ST_OP;
      cnt    <= '0;
    end else begin
      if (bus_ok && !reg_addr) ctl_q  <= {reg_wdata[7:3], 1'b1, reg_wdata[1:0]};
      if (bus_ok &&  reg_addr) ctl2_q <= {3'b000, reg_wdata[4:0]};

      if (!as_on || dev_hit || as_fire) cnt <= '0;
      else if (tick_32k)                cnt <= cnt + 1'b1;

      unique case (st)
        ST_OP: begin
          if (ctl_q[5]) begin
            st       <= ST_HIB;
            ctl_q[5] <= 1'b0;
            ctl_q[4] <= 1'b0;
          end else if (ctl_q[4]) begin
            st       <= ST_SLP;
            ctl_q[4] <= 1'b0;
          end else if (as_fire) begin
            st <= ST_SLP;
          end
        end
        ST_SLP: if (dev_hit || wake_evt) st <= ST_OP;
        ST_HIB: begin
          if (dev_hit)         st <= ST_OP;
          else if (key_detect) st <= ST_KEY;
        end
        ST_KEY: begin
          if (dev_hit)          st <= ST_OP;
          else if (key_invalid) st <= ST_HIB;
          else if (key_valid)   st <= ST_SLP;
        end
        default: st <= ST_OP;
      endcase
    end
  end

  p_soft_restore_r11: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_o |=> (ctl_q == CTL_RST && ctl2_q == 8'h00 && pwr_state == 2'b00 && !soft_rst_o));

  p_sleep_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_OP && !ctl_q[7] && !ctl_q[5] && ctl_q[4]) |=> (st == ST_SLP && !ctl_q[4]));

  p_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_SLP && !ctl_q[7] && (dev_hit || wake_evt)) |=> (st == ST_OP));

  p_hib_dark_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (pwr_state == 2'b10) |-> !(rc_osc_en || osc32_en || gpio_clk_en || kpc_clk_en || pwm_clk_en));

  p_hib_exit_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_HIB && !dev_hit && !ctl_q[7]) |=> (st != ST_OP));

  p_key_fail_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_KEY && !dev_hit && key_invalid && !ctl_q[7]) |=> (st == ST_HIB));

  p_cnt_bound_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (32'(cnt) < LIM_MAX));

  p_no_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (st != ST_OP && !ctl_q[7]) |=> $stable(ctl2_q));

endmodule

// File: tb/sim_pwr_mode_ctrl.sv
module sim_pwr_mode_ctrl;
  localparam int TPM = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic reg_wr = 0, reg_addr = 0, tick_32k = 0, dev_hit = 0, wake_evt = 0;
  logic key_detect = 0, key_valid = 0, key_invalid = 0;
  logic [7:0] reg_wdata = 0, ctl_q, ctl2_q;
  logic [1:0] pwr_state;
  logic rc_osc_en, osc32_en, ext32_sel, gpio_clk_en, kpc_clk_en, pwm_clk_en, io_hi_off, soft_rst_o;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  pwr_mode_ctrl #(.TICKS_PER_MS(TPM)) u0 (.*);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 0;
  endtask

  task automatic hit();
    dev_hit = 1; step(); dev_hit = 0;
  endtask

  task automatic report();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      report();
    end
  end

  initial begin
    int n, ms;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk("R1 ctl", ctl_q, 8'h0F);
    chk("R1 ctl2", ctl2_q, 0);
    chk("R1 state", pwr_state, 0);
    chk("R1 clocks", {rc_osc_en, osc32_en, gpio_clk_en, kpc_clk_en, pwm_clk_en}, 5'b11111);

    // R2 gating and reserved bit
    wr(0, 8'h00);
    chk("R2 ctl reserved", ctl_q, 8'h04);
    chk("R2 enables off", {gpio_clk_en, kpc_clk_en, pwm_clk_en}, 0);
    wr(0, 8'h0A);
    chk("R2 gpio/kpc", {gpio_clk_en, kpc_clk_en, pwm_clk_en}, 3'b110);
    wr(0, 8'h0F);

    // R3 sleep entry and self clear
    wr(0, 8'h1F);
    step();
    chk("R3 state", pwr_state, 1);
    chk("R3 bit clear", ctl_q, 8'h0F);
    chk("R3 osc", {rc_osc_en, osc32_en, gpio_clk_en}, 3'b011);
    // R10 write ignored in sleep
    wr(1, 8'h1D);
    chk("R10 ctl2 held", ctl2_q, 0);
    wr(0, 8'h00);
    chk("R10 ctl held", ctl_q, 8'h0F);
    // R4 wake by wake_evt
    wake_evt = 1; step(); wake_evt = 0;
    chk("R4 wake_evt", pwr_state, 0);
    wr(0, 8'h1F); step();
    hit();
    chk("R4 dev_hit", pwr_state, 0);

    // R5 hibernate wins over sleep
    wr(0, 8'h3F); step();
    chk("R5 state", pwr_state, 2);
    chk("R5 bits clear", ctl_q, 8'h0F);
    chk("R5 dark", {rc_osc_en, osc32_en, gpio_clk_en, kpc_clk_en, pwm_clk_en}, 0);
    // R6 wake_evt ignored in hibernate
    wake_evt = 1; step(); wake_evt = 0;
    chk("R6 wake ignored", pwr_state, 2);
    key_detect = 1; step(); key_detect = 0;
    chk("R6 key to sleep", pwr_state, 1);
    // R7 invalid returns to hibernate
    key_invalid = 1; step(); key_invalid = 0;
    chk("R7 invalid", pwr_state, 2);
    key_detect = 1; step(); key_detect = 0;
    key_valid = 1; step(); key_valid = 0;
    chk("R7 valid", pwr_state, 1);
    key_invalid = 1; step(); key_invalid = 0;
    chk("R7 stray invalid", pwr_state, 1);
    wake_evt = 1; step(); wake_evt = 0;
    chk("R4 from key sleep", pwr_state, 0);
    wr(0, 8'h2F); step();
    hit();
    chk("R6 dev_hit", pwr_state, 0);

    // R8 exhaustive timeout sweep
    for (int s = 0; s < 8; s++) begin
      ms = (s == 0) ? 4 : (8 << s);
      wr(1, 8'(8 | s));
      tick_32k = 1;
      n = 0;
      while (pwr_state != 2'd1 && n < 5000) begin
        step(); n++;
      end
      tick_32k = 0;
      chk($sformatf("R8 code %0d ticks", s), n, ms * TPM);
      hit();
      wr(1, 8'h00);
    end

    // R9 restart mid count, and hold while disabled
    wr(1, 8'h08);
    tick_32k = 1;
    repeat (5) step();
    dev_hit = 1; step(); dev_hit = 0;
    n = 0;
    while (pwr_state != 2'd1 && n < 100) begin
      step(); n++;
    end
    chk("R9 restart", n, 4 * TPM);
    tick_32k = 0;
    hit();
    wr(1, 8'h00);
    tick_32k = 1;
    repeat (20) step();
    chk("R9 disabled hold", pwr_state, 0);
    wr(1, 8'h08);
    n = 0;
    while (pwr_state != 2'd1 && n < 100) begin
      step(); n++;
    end
    chk("R9 fresh count", n, 4 * TPM);
    tick_32k = 0;
    hit();

    // R12 side fields
    wr(1, 8'hF0);
    chk("R12 ctl2 mask", ctl2_q, 8'h10);
    chk("R12 io off", io_hi_off, 1);
    wr(0, 8'h4F);
    chk("R12 ext sel", ext32_sel, 1);

    // R11 soft reset
    wr(1, 8'h1B);
    wr(0, 8'h80);
    chk("R11 pulse", soft_rst_o, 1);
    step();
    chk("R11 pulse width", soft_rst_o, 0);
    chk("R11 ctl", ctl_q, 8'h0F);
    chk("R11 ctl2", ctl2_q, 0);
    chk("R11 state", pwr_state, 0);
    chk("R11 ext off", {ext32_sel, io_hi_off}, 0);

    done = 1;
    report();
  end
endmodule